// File: doc/BRIEF.md
# Bank State Tracker with Group Fan-Out

This block holds the live state of every bank in one memory rank: whether the bank has a row open or is precharged, which row is open, whether the bank has been put to sleep by a power-down or self-refresh entry, and whether it has been blocked for refresh. Each cycle it may receive one issued command, given as a code, a bank index and a row address. It decodes the command and applies its effect to the banks the command reaches.

A command reaches banks in one of three ways. A rank-wide command touches every bank. A group-wide command addressed to bank b touches the bank with the same position inside each bank group. Those are banks b mod G, b mod G + G, b mod G + 2G and so on, where G is the number of banks per group. Any other command touches bank b alone.

A separate block-request input marks one bank as blocked. An external pending-request vector is combined with the flags to give a per-bank idle indication. Scheduling and timing checks belong to other blocks.

Top module: `bank_state_tracker`

## Requirements
- R1: An activate (code 1) on a valid command sets the addressed bank open and stores cmd_row as its open row, visible on the outputs one clock after issue.
- R2: A single-bank precharge (code 2), a precharge-all (code 3) and a same-position precharge (code 4) set each bank they reach to precharged, leaving that bank's stored row unchanged.
- R3: Precharge power-down entry (code 7), active power-down entry (code 8) and self-refresh entry (code 9) set the sleep flag of every bank.
- R4: All-bank refresh (code 10), single-bank refresh (code 11) and same-position refresh (code 12) clear both the sleep flag and the blocked flag of each bank they reach.
- R5: Codes 3, 7, 8, 9 and 10 reach every bank, whatever cmd_bank holds.
- R6: Codes 4 and 12 addressed to bank b reach exactly the banks whose index i satisfies i mod BANKS_PER_GROUP == b mod BANKS_PER_GROUP.
- R7: Codes 1, 2 and 11 reach only bank cmd_bank.
- R8: Codes 0, 5 (read), 6 (write) and 13 to 15 leave all state unchanged. Any code presented with cmd_valid low also leaves all state unchanged.
- R9: A block request sets the blocked flag of bank blk_bank one clock later. If a refresh clears the same bank in the same cycle, the blocked flag ends set.
- R10: bank_idle[i] is high exactly when bank i is neither blocked nor sleeping and pend_req[i] is low. It follows pend_req in the same cycle.
- R11: While rst is high at a clock edge, every bank becomes precharged with row 0, and its sleep and blocked flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 4 | Command code (see requirements) |
| cmd_bank | input | 4 | Addressed bank index |
| cmd_row | input | 16 | Row address for an activate |
| blk_valid | input | 1 | Block request this cycle |
| blk_bank | input | 4 | Bank to mark blocked |
| pend_req | input | 16 | Per-bank pending-request flags |
| bank_open | output | 16 | Per-bank open (1) or precharged (0) |
| bank_sleep | output | 16 | Per-bank sleep flag |
| bank_blocked | output | 16 | Per-bank blocked flag |
| open_row | output | 256 | Stored row per bank, bank i at bits [16i+15:16i] |
| bank_idle | output | 16 | Per-bank idle indication |

## Verification
A block request and a refresh that clears the blocked flag can land on the same bank in the same cycle. The result depends on which of the two wins. The bench issues a single-bank refresh to a bank while also requesting a block on that bank, and expects the blocked flag to be set afterwards. The random phase produces the same collision through group-wide and rank-wide refreshes. A per-cycle reference model predicts every flag and row, and the bench compares them against the outputs on each clock.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_NOP      = 4'd0;
    localparam logic [CMD_W-1:0] CMD_ACT      = 4'd1;
    localparam logic [CMD_W-1:0] CMD_PRE      = 4'd2;
    localparam logic [CMD_W-1:0] CMD_PRE_ALL  = 4'd3;
    localparam logic [CMD_W-1:0] CMD_PRE_POS  = 4'd4;
    localparam logic [CMD_W-1:0] CMD_RD       = 4'd5;
    localparam logic [CMD_W-1:0] CMD_WR       = 4'd6;
    localparam logic [CMD_W-1:0] CMD_PD_PRE   = 4'd7;
    localparam logic [CMD_W-1:0] CMD_PD_ACT   = 4'd8;
    localparam logic [CMD_W-1:0] CMD_SR_ENTER = 4'd9;
    localparam logic [CMD_W-1:0] CMD_REF_ALL  = 4'd10;
    localparam logic [CMD_W-1:0] CMD_REF_ONE  = 4'd11;
    localparam logic [CMD_W-1:0] CMD_REF_POS  = 4'd12;

    // Which banks a command reaches
    typedef enum logic [1:0] {
        SCOPE_NONE  = 2'd0,
        SCOPE_RANK  = 2'd1,
        SCOPE_GROUP = 2'd2,
        SCOPE_BANK  = 2'd3
    } scope_e;

    // What a command does to each bank it reaches
    typedef enum logic [2:0] {
        EFF_NONE  = 3'd0,
        EFF_OPEN  = 3'd1,
        EFF_CLOSE = 3'd2,
        EFF_SLEEP = 3'd3,
        EFF_WAKE  = 3'd4
    } eff_e;

    typedef struct packed {
        scope_e scope;
        eff_e   eff;
    } cmd_info_t;

    typedef struct packed {
        logic open;
        logic sleep;
        logic blocked;
    } bank_flags_t;

    function automatic cmd_info_t decode_cmd(input logic [CMD_W-1:0] code);
        cmd_info_t info;
        info.scope = SCOPE_NONE;
        info.eff   = EFF_NONE;
        case (code)
            CMD_ACT:      begin info.scope = SCOPE_BANK;  info.eff = EFF_OPEN;  end
            CMD_PRE:      begin info.scope = SCOPE_BANK;  info.eff = EFF_CLOSE; end
            CMD_PRE_ALL:  begin info.scope = SCOPE_RANK;  info.eff = EFF_CLOSE; end
            CMD_PRE_POS:  begin info.scope = SCOPE_GROUP; info.eff = EFF_CLOSE; end
            CMD_PD_PRE,
            CMD_PD_ACT,
            CMD_SR_ENTER: begin info.scope = SCOPE_RANK;  info.eff = EFF_SLEEP; end
            CMD_REF_ALL:  begin info.scope = SCOPE_RANK;  info.eff = EFF_WAKE;  end
            CMD_REF_ONE:  begin info.scope = SCOPE_BANK;  info.eff = EFF_WAKE;  end
            CMD_REF_POS:  begin info.scope = SCOPE_GROUP; info.eff = EFF_WAKE;  end
            default:      begin info.scope = SCOPE_NONE;  info.eff = EFF_NONE;  end
        endcase
        return info;
    endfunction

endpackage

// File: rtl/bank_cmd_router.sv
module bank_cmd_router
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS       = 16,
    parameter int BANKS_PER_GROUP = 4,
    localparam int BANK_W         = $clog2(NUM_BANKS),
    localparam int HITS_PER_GROUP = NUM_BANKS / BANKS_PER_GROUP
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  scope_e               scope,
    input  logic [BANK_W-1:0]    bank,
    output logic [NUM_BANKS-1:0] hit
);

    logic [BANK_W-1:0] pos_sel;
    assign pos_sel = BANK_W'(32'(bank) % BANKS_PER_GROUP);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_hit
        localparam logic [BANK_W-1:0] MY_POS = BANK_W'(i % BANKS_PER_GROUP);
        localparam logic [BANK_W-1:0] MY_IDX = BANK_W'(i);
        always_comb begin
            hit[i] = 1'b0;
            if (valid) begin
                unique case (scope)
                    SCOPE_RANK:  hit[i] = 1'b1;
                    SCOPE_GROUP: hit[i] = (pos_sel == MY_POS);
                    SCOPE_BANK:  hit[i] = (bank == MY_IDX);
                    default:     hit[i] = 1'b0;
                endcase
            end
        end
    end

    // R5
    rank_fanout_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && scope == SCOPE_RANK) |-> (&hit));
    // R6
    group_fanout_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && scope == SCOPE_GROUP) |-> ($countones(hit) == HITS_PER_GROUP && hit[pos_sel]));
    // R7
    single_fanout_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && scope == SCOPE_BANK) |-> ($countones(hit) == 1 && hit[bank]));
    // R8
    no_fanout_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid || scope == SCOPE_NONE) |-> (hit == '0));

endmodule

// File: rtl/bank_state_cell.sv
module bank_state_cell
    import bank_trk_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  eff_e             eff,
    input  logic [ROW_W-1:0] row_in,
    input  logic             blk_set,
    input  logic             pend,
    output bank_flags_t      flags_q,
    output logic [ROW_W-1:0] row_q,
    output logic             idle
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            row_q   <= '0;
        end else begin
            if (hit) begin
                case (eff)
                    EFF_OPEN: begin
                        flags_q.open <= 1'b1;
                        row_q        <= row_in;
                    end
                    EFF_CLOSE: flags_q.open  <= 1'b0;
                    EFF_SLEEP: flags_q.sleep <= 1'b1;
                    EFF_WAKE: begin
                        flags_q.sleep   <= 1'b0;
                        flags_q.blocked <= 1'b0;
                    end
                    default: ;
                endcase
            end
            // a block request in the same cycle outranks a refresh clear
            if (blk_set)
                flags_q.blocked <= 1'b1;
        end
    end

    assign idle = !flags_q.blocked && !flags_q.sleep && !pend;

    // R1
    open_row_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && eff == EFF_OPEN) |=> (flags_q.open && row_q == $past(row_in)));
    // R2
    close_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && eff == EFF_CLOSE) |=> (!flags_q.open && $stable(row_q)));
    // R3
    sleep_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && eff == EFF_SLEEP) |=> flags_q.sleep);
    // R4
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && eff == EFF_WAKE) |=> (!flags_q.sleep && flags_q.blocked == $past(blk_set)));
    // R9
    block_set_chk: assert property (@(posedge clk) disable iff (rst)
        blk_set |=> flags_q.blocked);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit && !blk_set) |=> ($stable(flags_q) && $stable(row_q)));

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS       = 16,
    parameter int BANKS_PER_GROUP = 4,
    parameter int ROW_W           = 16,
    localparam int BANK_W         = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [CMD_W-1:0]           cmd_code,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic                       blk_valid,
    input  logic [BANK_W-1:0]          blk_bank,
    input  logic [NUM_BANKS-1:0]       pend_req,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS-1:0]       bank_sleep,
    output logic [NUM_BANKS-1:0]       bank_blocked,
    output logic [NUM_BANKS*ROW_W-1:0] open_row,
    output logic [NUM_BANKS-1:0]       bank_idle
);

    cmd_info_t            info;
    logic [NUM_BANKS-1:0] hit;

    assign info = decode_cmd(cmd_code);

    bank_cmd_router #(
        .NUM_BANKS      (NUM_BANKS),
        .BANKS_PER_GROUP(BANKS_PER_GROUP)
    ) i_router (
        .clk  (clk),
        .rst  (rst),
        .valid(cmd_valid),
        .scope(info.scope),
        .bank (cmd_bank),
        .hit  (hit)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        bank_flags_t      flags;
        logic [ROW_W-1:0] row;
        logic             blk_here;

        assign blk_here = blk_valid && (blk_bank == BANK_W'(i));

        bank_state_cell #(.ROW_W(ROW_W)) i_cell (
            .clk    (clk),
            .rst    (rst),
            .hit    (hit[i]),
            .eff    (info.eff),
            .row_in (cmd_row),
            .blk_set(blk_here),
            .pend   (pend_req[i]),
            .flags_q(flags),
            .row_q  (row),
            .idle   (bank_idle[i])
        );

        assign bank_open[i]                = flags.open;
        assign bank_sleep[i]               = flags.sleep;
        assign bank_blocked[i]             = flags.blocked;
        assign open_row[i*ROW_W +: ROW_W]  = row;
    end

endmodule

// File: tb/test_bank_state_tracker.sv
`timescale 1ns/1ps
module test_bank_state_tracker;

    localparam int N  = 16;
    localparam int G  = 4;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_code = '0;
    logic [3:0]    cmd_bank = '0;
    logic [RW-1:0] cmd_row = '0;
    logic          blk_valid = 1'b0;
    logic [3:0]    blk_bank = '0;
    logic [N-1:0]  pend_req = '0;
    logic [N-1:0]  bank_open, bank_sleep, bank_blocked, bank_idle;
    logic [N*RW-1:0] open_row;

    bank_state_tracker i_bank_state_tracker (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .blk_valid(blk_valid), .blk_bank(blk_bank), .pend_req(pend_req),
        .bank_open(bank_open), .bank_sleep(bank_sleep), .bank_blocked(bank_blocked),
        .open_row(open_row), .bank_idle(bank_idle)
    );

    always #2 clk = ~clk;

    // reference model state
    bit m_open [N];
    bit m_sleep[N];
    bit m_blk  [N];
    int m_row  [N];

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    done   = 0;
    string last_tag = "R11";

    function automatic int scope_of(int code);
        case (code)
            3, 7, 8, 9, 10: return 1;  // every bank
            4, 12:          return 2;  // same position in each group
            1, 2, 11:       return 3;  // one bank
            default:        return 0;
        endcase
    endfunction

    function automatic string tag_of(bit v, int code, bit bv);
        string t;
        if (!v) t = "R8";
        else case (code)
            1:        t = "R1 R7";
            2:        t = "R2 R7";
            3:        t = "R2 R5";
            4:        t = "R2 R6";
            7, 8, 9:  t = "R3 R5";
            10:       t = "R4 R5";
            11:       t = "R4 R7";
            12:       t = "R4 R6";
            default:  t = "R8";
        endcase
        if (bv) t = {t, " R9"};
        return t;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_open[i] = 0; m_sleep[i] = 0; m_blk[i] = 0; m_row[i] = 0;
        end
    endtask

    task automatic model_step(bit v, int code, int bank, int row, bit bv, int bb);
        int sc = scope_of(code);
        for (int i = 0; i < N; i++) begin
            bit h = v && ((sc == 1) || (sc == 2 && (i % G) == (bank % G)) || (sc == 3 && i == bank));
            if (h) begin
                case (code)
                    1:          begin m_open[i] = 1; m_row[i] = row; end
                    2, 3, 4:    m_open[i] = 0;
                    7, 8, 9:    m_sleep[i] = 1;
                    10, 11, 12: begin m_sleep[i] = 0; m_blk[i] = 0; end
                    default: ;
                endcase
            end
            if (bv && bb == i) m_blk[i] = 1;
        end
    endtask

    task automatic check_vec(string what, string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [N-1:0]    e_open, e_sleep, e_blk, e_idle;
        logic [N*RW-1:0] e_row;
        for (int i = 0; i < N; i++) begin
            e_open[i]  = m_open[i];
            e_sleep[i] = m_sleep[i];
            e_blk[i]   = m_blk[i];
            e_idle[i]  = !m_blk[i] && !m_sleep[i] && !pend_req[i];
            e_row[i*RW +: RW] = RW'(m_row[i]);
        end
        check_vec("open",    last_tag, bank_open,    e_open);
        check_vec("sleep",   last_tag, bank_sleep,   e_sleep);
        check_vec("blocked", last_tag, bank_blocked, e_blk);
        check_vec("idle",    "R10",    bank_idle,    e_idle);
        n_cmp++;
        if (open_row !== e_row) begin
            n_bad++;
            $display("FAIL %s row: actual %h expected %h", last_tag, open_row, e_row);
        end
    endtask

    task automatic step(bit v, int code, int bank, int row, bit bv, int bb, logic [N-1:0] pd);
        @(negedge clk);
        compare_all();
        cmd_valid = v; cmd_code = 4'(code); cmd_bank = 4'(bank); cmd_row = RW'(row);
        blk_valid = bv; blk_bank = 4'(bb); pend_req = pd;
        model_step(v, code, bank, row, bv, bb);
        last_tag = tag_of(v, code, bv);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // first compare checks the reset state (R11)
        step(1, 1, 5, 'h1234, 0, 0, '0);      // R1 activate bank 5
        step(1, 1, 9, 'hBEEF, 0, 0, '0);      // R1 activate bank 9
        step(1, 4, 1, 0, 0, 0, '0);           // R6 R2 banks 1,5,9,13 precharged
        step(0, 1, 3, 7, 0, 0, '0);           // R8 not valid
        step(1, 5, 3, 0, 0, 0, 16'h00F0);     // R8 read, R10 pending
        step(1, 14, 3, 0, 0, 0, '0);          // R8 unassigned code
        step(1, 9, 0, 0, 0, 0, '0);           // R3 self-refresh entry, all sleep
        step(1, 12, 6, 0, 0, 0, '0);          // R4 R6 wake banks 2,6,10,14
        step(1, 11, 6, 0, 1, 6, '0);          // R9 block wins over refresh on bank 6
        step(1, 10, 0, 0, 1, 3, '0);          // R4 R5 all-bank refresh with block on 3
        step(1, 8, 12, 0, 0, 0, '0);          // R3 active power-down entry
        step(1, 11, 0, 0, 0, 0, 16'h0001);    // R4 R7 only bank 0 wakes
        step(1, 1, 15, 'h00AA, 0, 0, '0);     // R1 activate last bank
        step(1, 3, 7, 0, 0, 0, '0);           // R2 R5 precharge-all
        for (int k = 0; k < 2000; k++) begin
            bit v  = ($urandom % 5) != 0;
            bit bv = ($urandom % 5) == 0;
            step(v, int'($urandom % 16), int'($urandom % N), int'($urandom % 65536),
                 bv, int'($urandom % N), N'($urandom));
        end
        @(negedge clk);
        compare_all();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule